// File: doc/BRIEF.md
# Microsecond Countdown Timer

A single programmable down-counter driven by a selectable tick-enable input. Software writes one 32-bit control word holding the run enable, the repeat mode and a 28-bit reload value. The counter steps down once for each tick of the selected source. When a tick arrives while the counter is already at zero, the timer expires.

On expiry the block sets a sticky interrupt flag, shown on `irq` and in a status word. It also drives `expire_pulse` high for one clock so that a watchdog or another escalation stage can count expirations. In repeat mode the counter reloads and keeps running. In single-shot mode the timer drops its own enable after the first expiry.

A flat register port serves the three words. Writes happen on the clock edge when `bus_wr` is high. Reads are combinational on `bus_addr`.

Top module: `usec_countdown_timer`

## Requirements
- R1: After reset, the control, status and source-select words all read 0, and `irq` and `expire_pulse` are low.
- R2: The control word sits at byte offset 0x000. Bit 31 is the run enable, bit 30 selects repeat mode (1) or single-shot (0), and bits 27:0 hold the reload value. It reads back in the same layout, with bits 29:28 reading 0.
- R3: A control write with bit 31 set loads the reload value R into the counter. The first expiry happens on the (R+1)th selected tick after that write.
- R4: The counter moves only on clock edges where the selected tick input is high. Cycles without a tick change nothing.
- R5: On expiry, bit 30 of the status word (offset 0x004) and `irq` go high on the same edge as the expiring tick. On that same edge `expire_pulse` goes high, and it stays high for exactly one clock.
- R6: The status flag stays set until software writes 1 to bit 30 of the status word. Writing 0 to bit 30 leaves the flag unchanged.
- R7: If an expiry and a status clear land on the same edge, the flag ends up set.
- R8: In repeat mode the counter reloads R after each expiry and expires again every R+1 selected ticks. The enable stays set.
- R9: In single-shot mode the first expiry clears the enable bit, which reads 0 afterwards. No further expiry follows, whatever ticks arrive.
- R10: Writing 0 to the control word stops the timer: later ticks raise no expiry.
- R11: The source-select word at offset 0x008 uses bits 1:0 to pick which tick input drives the counter. Value 0 picks input 0, the microsecond tick. The word reads back what was written.
- R12: A control write with the enable set, made while the timer is running, restarts the count from the new reload value. A write on the same edge as a tick takes priority over that tick.
- R13: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 4 | Tick-enable sources; index 0 is the microsecond tick |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 12 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Sticky interrupt-pending flag |
| expire_pulse | output | 1 | One-clock pulse per expiry |

## Verification
A register write takes effect on the edge that samples it, and the new value reads back in the cycle after. A tick that is high before an edge is applied on that edge. The status flag, `irq` and `expire_pulse` therefore all show the result one cycle after the expiring tick is driven, and `expire_pulse` is low again one cycle after that. The bench drives every input on the falling edge and checks outputs on the next falling edge, half a clock after the edge that updates them. That holds each check to the exact cycle in which a result is due.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int RELOAD_W = 28;
    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = $clog2(NUM_SRC);

    localparam int EN_BIT   = DATA_W - 1;
    localparam int MODE_BIT = DATA_W - 2;
    localparam int IRQ_BIT  = 30;
    localparam int PAD_W    = DATA_W - 2 - RELOAD_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12'h004);
    localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(12'h008);

    typedef logic [RELOAD_W-1:0] count_t;
    typedef logic [SEL_W-1:0]    src_sel_t;

    typedef struct packed {
        logic   run;
        logic   repeat_mode;
        count_t reload;
    } ctrl_word_t;

    function automatic ctrl_word_t decode_ctrl(input logic [DATA_W-1:0] d);
        ctrl_word_t c;
        c.run         = d[EN_BIT];
        c.repeat_mode = d[MODE_BIT];
        c.reload      = d[RELOAD_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] encode_ctrl(input ctrl_word_t c);
        return {c.run, c.repeat_mode, {PAD_W{1'b0}}, c.reload};
    endfunction

endpackage

// File: rtl/timer_tick_mux.sv
module timer_tick_mux
    import timer_pkg::*;
(
    input  logic [NUM_SRC-1:0] tick_in,
    input  src_sel_t           sel,
    output logic               tick_out
);

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = tick_in[i] && (sel == SEL_W'(i));
    end

    assign tick_out = |hit;

endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_word_t ctrl_new,
    input  logic       tick,
    output ctrl_word_t ctrl_cur,
    output logic       expire_now,
    output logic       expire_pulse
);

    ctrl_word_t ctrl_q;
    count_t     count_q;
    logic       pulse_q;
    logic       at_zero;

    assign at_zero      = (count_q == '0);
    assign expire_now   = ctrl_q.run && tick && at_zero && !ctrl_wr;
    assign ctrl_cur     = ctrl_q;
    assign expire_pulse = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            count_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire_now;
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
                if (ctrl_new.run) begin
                    count_q <= ctrl_new.reload;
                end
            end else if (ctrl_q.run && tick) begin
                if (at_zero) begin
                    if (ctrl_q.repeat_mode) begin
                        count_q <= ctrl_q.reload;
                    end else begin
                        ctrl_q.run <= 1'b0;
                    end
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_new.run) |=> (count_q == $past(ctrl_new.reload))); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_wr) |=> $stable(count_q)); // R4

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(tick)); // R5

    AST_REPEAT_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (expire_now && ctrl_q.repeat_mode) |=> ctrl_q.run); // R8

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (expire_now && !ctrl_q.repeat_mode) |=> !ctrl_q.run); // R9

    AST_IDLE_NO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !ctrl_wr) |=> !pulse_q); // R10

endmodule

// File: rtl/timer_regif.sv
module timer_regif
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  ctrl_word_t        ctrl_cur,
    input  logic              expire_now,
    output logic              ctrl_wr,
    output ctrl_word_t        ctrl_new,
    output src_sel_t          src_sel,
    output logic              irq
);

    logic     stat_wr;
    logic     sel_wr;
    logic     clr_req;
    logic     pend_q;
    src_sel_t sel_q;
    logic     unused_wbits;

    assign ctrl_wr  = bus_wr && (bus_addr == OFF_CTRL);
    assign stat_wr  = bus_wr && (bus_addr == OFF_STAT);
    assign sel_wr   = bus_wr && (bus_addr == OFF_SEL);
    assign clr_req  = stat_wr && bus_wdata[IRQ_BIT];
    assign ctrl_new = decode_ctrl(bus_wdata);
    assign src_sel  = sel_q;
    assign irq      = pend_q;
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (expire_now) begin
                pend_q <= 1'b1;
            end else if (clr_req) begin
                pend_q <= 1'b0;
            end
            if (sel_wr) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: bus_rdata = encode_ctrl(ctrl_cur);
            OFF_STAT: bus_rdata[IRQ_BIT] = pend_q;
            OFF_SEL:  bus_rdata[SEL_W-1:0] = sel_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_req) |=> pend_q); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        expire_now |=> pend_q); // R7

    AST_PEND_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(expire_now)); // R5

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(sel_q)); // R11

endmodule

// File: rtl/usec_countdown_timer.sv
module usec_countdown_timer
    import timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tick_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq,
    output logic               expire_pulse
);

    ctrl_word_t ctrl_cur;
    ctrl_word_t ctrl_new;
    logic       ctrl_wr;
    logic       expire_now;
    logic       tick_sel;
    src_sel_t   src_sel;

    timer_regif u_regif (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ctrl_cur   (ctrl_cur),
        .expire_now (expire_now),
        .ctrl_wr    (ctrl_wr),
        .ctrl_new   (ctrl_new),
        .src_sel    (src_sel),
        .irq        (irq)
    );

    timer_tick_mux u_mux (
        .tick_in  (tick_in),
        .sel      (src_sel),
        .tick_out (tick_sel)
    );

    timer_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_new     (ctrl_new),
        .tick         (tick_sel),
        .ctrl_cur     (ctrl_cur),
        .expire_now   (expire_now),
        .expire_pulse (expire_pulse)
    );

    AST_PULSE_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |-> irq); // R5

endmodule

// File: tb/sim_usec_countdown_timer.sv
module sim_usec_countdown_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  tick_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        expire_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usec_countdown_timer u0 (
        .clk (clk), .rst (rst), .tick_in (tick_in),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq (irq), .expire_pulse (expire_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic tick(input int idx);
        @(negedge clk);
        tick_in[idx] = 1'b1;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic clear_irq();
        wr(12'h004, 32'h4000_0000);
    endtask

    function automatic logic [31:0] ctrl(input bit en, input bit per, input int r);
        return {en, per, 2'b00, 28'(r)};
    endfunction

    task automatic t_reset();
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 pulse", {31'b0, expire_pulse}, 32'd0);
        rd_check("R1 ctrl", 12'h000, 32'd0);
        rd_check("R1 status", 12'h004, 32'd0);
        rd_check("R1 sel", 12'h008, 32'd0);
    endtask

    task automatic t_layout();
        wr(12'h000, 32'h7fff_fff5);
        rd_check("R2 ctrl readback", 12'h000, 32'h4fff_fff5);
        wr(12'h000, 32'h0000_0000);
        rd_check("R2 ctrl cleared", 12'h000, 32'd0);
    endtask

    task automatic t_unmapped();
        rd_check("R13 offset 0x00c", 12'h00c, 32'd0);
        rd_check("R13 offset 0x100", 12'h100, 32'd0);
    endtask

    task automatic t_oneshot();
        bit early = 1'b0;
        wr(12'h000, ctrl(1, 0, 3));
        for (int i = 0; i < 3; i++) begin
            tick(0);
            if (expire_pulse) early = 1'b1;
        end
        check("R3 no early expiry", {31'b0, early}, 32'd0);
        tick(0);
        check("R3 expiry on 4th tick", {31'b0, expire_pulse}, 32'd1);
        check("R5 irq set", {31'b0, irq}, 32'd1);
        rd_check("R5 status bit30", 12'h004, 32'h4000_0000);
        @(negedge clk);
        check("R5 pulse one cycle", {31'b0, expire_pulse}, 32'd0);
        rd_check("R9 enable dropped", 12'h000, ctrl(0, 0, 3));
        tick(0);
        check("R9 no second expiry", {31'b0, expire_pulse}, 32'd0);
        clear_irq();
    endtask

    task automatic t_no_tick();
        wr(12'h000, ctrl(1, 0, 1));
        repeat (20) @(negedge clk);
        check("R4 idle cycles", {31'b0, irq}, 32'd0);
        tick(0);
        check("R4 one tick no expiry", {31'b0, expire_pulse}, 32'd0);
        repeat (5) @(negedge clk);
        tick(0);
        check("R4 second tick expires", {31'b0, expire_pulse}, 32'd1);
    endtask

    task automatic t_sticky();
        repeat (4) @(negedge clk);
        check("R6 still pending", {31'b0, irq}, 32'd1);
        wr(12'h004, 32'hbfff_ffff);
        check("R6 write 0 to bit30 ignored", {31'b0, irq}, 32'd1);
        clear_irq();
        check("R6 cleared", {31'b0, irq}, 32'd0);
        rd_check("R6 status reads 0", 12'h004, 32'd0);
    endtask

    task automatic t_collide();
        wr(12'h000, ctrl(1, 0, 0));
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h4000_0000;
        tick_in[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; tick_in = '0;
        check("R7 pulse", {31'b0, expire_pulse}, 32'd1);
        check("R7 set wins over clear", {31'b0, irq}, 32'd1);
        clear_irq();
    endtask

    task automatic t_periodic();
        int pulses = 0;
        wr(12'h000, ctrl(1, 1, 2));
        for (int i = 1; i <= 9; i++) begin
            tick(0);
            if (expire_pulse) begin
                pulses++;
                check("R8 expiry tick spacing", 32'(i % 3), 32'd0);
            end
        end
        check("R8 three expiries", 32'(pulses), 32'd3);
        rd_check("R8 enable kept", 12'h000, ctrl(1, 1, 2));
    endtask

    task automatic t_stop();
        bit any = 1'b0;
        wr(12'h000, 32'd0);
        clear_irq();
        for (int i = 0; i < 6; i++) begin
            tick(0);
            if (expire_pulse) any = 1'b1;
        end
        check("R10 stopped no pulse", {31'b0, any}, 32'd0);
        check("R10 stopped no irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_srcsel();
        bit any = 1'b0;
        wr(12'h008, 32'h0000_0002);
        rd_check("R11 sel readback", 12'h008, 32'd2);
        wr(12'h000, ctrl(1, 0, 1));
        for (int i = 0; i < 4; i++) begin
            tick(0);
            if (expire_pulse) any = 1'b1;
        end
        check("R11 unselected source ignored", {31'b0, any}, 32'd0);
        tick(2);
        check("R11 first selected tick", {31'b0, expire_pulse}, 32'd0);
        tick(2);
        check("R11 selected source expires", {31'b0, expire_pulse}, 32'd1);
        wr(12'h008, 32'd0);
        clear_irq();
        wr(12'h000, ctrl(1, 0, 0));
        tick(0);
        check("R11 source 0 is usec tick", {31'b0, expire_pulse}, 32'd1);
        clear_irq();
    endtask

    task automatic t_restart();
        bit early = 1'b0;
        wr(12'h000, ctrl(1, 0, 2));
        tick(0);
        tick(0);
        wr(12'h000, ctrl(1, 0, 2));
        for (int i = 0; i < 2; i++) begin
            tick(0);
            if (expire_pulse) early = 1'b1;
        end
        check("R12 restart delays expiry", {31'b0, early}, 32'd0);
        tick(0);
        check("R12 expiry after restart", {31'b0, expire_pulse}, 32'd1);
        clear_irq();
        wr(12'h000, ctrl(1, 0, 0));
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = ctrl(1, 0, 1);
        tick_in[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; tick_in = '0;
        check("R12 write beats tick", {31'b0, expire_pulse}, 32'd0);
        tick(0);
        check("R12 new value counted", {31'b0, expire_pulse}, 32'd0);
        tick(0);
        check("R12 expiry from new value", {31'b0, expire_pulse}, 32'd1);
        clear_irq();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_unmapped();
        t_oneshot();
        t_no_tick();
        t_sticky();
        t_collide();
        t_periodic();
        t_stop();
        t_srcsel();
        t_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule